// File: doc/BRIEF.md
# Inclusive L2 Back-Invalidation Controller

This block handles line replacement in a shared second-level cache that holds every line the private first-level caches of a multicore chip hold. Each L2 line has a tag, a coherence state and a sharer vector with one bit per private L1. Instruction and data caches count separately, so each core owns two bits. A fill request names a set. If that set has a free (Invalid) way, the fill is accepted at once. If not, the controller picks a victim way.

The victim is evicted before its way is reused. Invalidates go out in parallel to every L1 whose sharer bit is set. Once every one of them has acknowledged, a single writeback is issued when the line or any returned copy is dirty. The way is then freed and the waiting fill installs into it. Data arrays, arbitration between cores and off-chip coherence live elsewhere.

Top module: `inclusive_l2_evictor`

## Requirements
- R1: After reset every line in every set is Invalid. `fill_ready` is high, `fill_way` reads 0 for any set, `inv_req` is all zero and `wb_valid` is low.
- R2: When the addressed set has an Invalid way, `fill_ready` is high and `fill_way` names the lowest-numbered Invalid way. A fill is accepted on a clock edge where `fill_valid` and `fill_ready` are both high, and it installs into that way.
- R3: In a full set the victim comes from a binary-tree pseudo-LRU, updated on every accepted fill. The tree bit points away from the way just filled, and a 0 bit steers the search towards lower-numbered ways. For four ways filled 0,1,2,3 in that order and then refilled in victim order, the victims repeat as 0,2,1,3.
- R4: While an eviction is in progress, `fill_ready` stays low. It rises only after the victim way has been freed, and `fill_way` then names the victim.
- R5: The invalidation phase drives `inv_req` equal to the victim's sharer vector, all bits at once. `inv_set` and `inv_tag` carry the victim's address. Bit 2c stands for the instruction L1 of core c and bit 2c+1 for its data L1. The sharer vector is the one supplied with the fill that installed the line.
- R6: Each `inv_req` bit stays high until the cycle after a matching `inv_ack` bit. An `inv_ack` or `inv_dirty` bit on an L1 whose request is not pending is ignored and does not trigger a writeback.
- R7: A victim whose sharer vector is all zero is evicted with no invalidation phase.
- R8: Exactly one writeback is issued when the victim's state is Owned or Modified, or when some pending L1 acknowledged with `inv_dirty` high. Otherwise no writeback is issued. State encoding: Invalid 0, Shared 1, Owned 2, Modified 3. The writeback follows the last acknowledgement.
- R9: `wb_valid` stays high with `wb_set` and `wb_tag` unchanged until the clock edge on which `wb_ready` is high.
- R10: Sets are independent. An eviction or fill in one set leaves the free ways and victim order of the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | A way is free, so the fill is taken this edge |
| fill_set | input | SET_W | Set index of the fill |
| fill_tag | input | TAG_W | Tag of the incoming line |
| fill_state | input | 2 | L2 state to record for the incoming line |
| fill_sharers | input | 2*CORES | L1s that will hold the incoming line |
| fill_way | output | WAY_W | Way the fill goes to (meaningful while fill_ready) |
| inv_req | output | 2*CORES | Per-L1 invalidate request, held until acknowledged |
| inv_set | output | SET_W | Set of the line being invalidated |
| inv_tag | output | TAG_W | Tag of the line being invalidated |
| inv_ack | input | 2*CORES | Per-L1 single-cycle acknowledge |
| inv_dirty | input | 2*CORES | Acknowledging L1 held modified data |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback taken |
| wb_set | output | SET_W | Set of the written-back line |
| wb_tag | output | TAG_W | Tag of the written-back line |

## Verification
The bench fills one set and then sweeps many evictions across every state, a rotating sharer pattern and several dirty-acknowledge masks. It acknowledges one L1 per cycle and sprays acks flagged dirty onto L1s that were never asked. A controller that counted those stray acks would write back clean lines. One that dropped a request before its ack, or dropped the ack bookkeeping, would show the wrong `inv_req` partway through the phase or hang. A wrong tree update or a missing preference for Invalid ways shows as a victim out of the 0,2,1,3 order. The bench delays `wb_ready` for three cycles and counts exactly three `wb_valid` cycles, so a dropped or repeated writeback is seen. It finally checks that an untouched set still offers way 0.

// File: rtl/inclusive_l2_evictor.sv
module inclusive_l2_evictor #(
  parameter int CORES = 2,
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  localparam int NL1   = 2 * CORES,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [1:0]       fill_state,
  input  logic [NL1-1:0]   fill_sharers,
  output logic [WAY_W-1:0] fill_way,
  output logic [NL1-1:0]   inv_req,
  output logic [SET_W-1:0] inv_set,
  output logic [TAG_W-1:0] inv_tag,
  input  logic [NL1-1:0]   inv_ack,
  input  logic [NL1-1:0]   inv_dirty,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [SET_W-1:0] wb_set,
  output logic [TAG_W-1:0] wb_tag
);

  typedef enum logic [1:0] {PH_IDLE, PH_INV, PH_WB} phase_t;

  phase_t           phase;
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [1:0]       st_q   [SETS][WAYS];
  logic [NL1-1:0]   sh_q   [SETS][WAYS];
  logic [WAYS-1:0]  plru_q [SETS];

  logic [SET_W-1:0] v_set;
  logic [WAY_W-1:0] v_way;
  logic [TAG_W-1:0] v_tag;
  logic [NL1-1:0]   pend;
  logic             dirty;

  logic             has_free;
  logic [WAY_W-1:0] free_way, lru_way, vic_way;
  logic [WAY_W:0]   walk, touch;
  logic [WAYS-1:0]  plru_upd;
  logic [NL1-1:0]   ack_hit, pend_left;
  logic             ack_dirty;

  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (st_q[fill_set][w] == 2'd0) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    walk = (WAY_W + 1)'(1);
    for (int l = 0; l < WAY_W; l++)
      walk = {walk[WAY_W-1:0], plru_q[fill_set][walk[WAY_W-1:0]]};
    lru_way = walk[WAY_W-1:0];
    vic_way = has_free ? free_way : lru_way;
  end

  always_comb begin
    plru_upd = plru_q[fill_set];
    touch    = {1'b1, vic_way};
    for (int l = 0; l < WAY_W; l++) begin
      plru_upd[touch[WAY_W:1]] = ~touch[0];
      touch = touch >> 1;
    end
  end

  assign ack_hit    = inv_ack & pend;
  assign ack_dirty  = |(ack_hit & inv_dirty);
  assign pend_left  = pend & ~inv_ack;

  assign fill_ready = (phase == PH_IDLE) && has_free;
  assign fill_way   = vic_way;
  assign inv_req    = (phase == PH_INV) ? pend : '0;
  assign inv_set    = v_set;
  assign inv_tag    = v_tag;
  assign wb_valid   = (phase == PH_WB);
  assign wb_set     = v_set;
  assign wb_tag     = v_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      v_set <= '0;
      v_way <= '0;
      v_tag <= '0;
      pend  <= '0;
      dirty <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          st_q[s][w]  <= 2'd0;
          sh_q[s][w]  <= '0;
        end
      end
    end else begin
      case (phase)
        PH_IDLE:
          if (fill_valid) begin
            if (has_free) begin
              tag_q[fill_set][vic_way] <= fill_tag;
              st_q[fill_set][vic_way]  <= fill_state;
              sh_q[fill_set][vic_way]  <= fill_sharers;
              plru_q[fill_set]         <= plru_upd;
            end else begin
              v_set <= fill_set;
              v_way <= vic_way;
              v_tag <= tag_q[fill_set][vic_way];
              pend  <= sh_q[fill_set][vic_way];
              dirty <= st_q[fill_set][vic_way][1];
              if (|sh_q[fill_set][vic_way])
                phase <= PH_INV;
              else if (st_q[fill_set][vic_way][1])
                phase <= PH_WB;
              else begin
                st_q[fill_set][vic_way] <= 2'd0;
                sh_q[fill_set][vic_way] <= '0;
              end
            end
          end
        PH_INV: begin
          pend  <= pend_left;
          dirty <= dirty | ack_dirty;
          if (pend_left == '0) begin
            if (dirty || ack_dirty)
              phase <= PH_WB;
            else begin
              st_q[v_set][v_way] <= 2'd0;
              sh_q[v_set][v_way] <= '0;
              phase <= PH_IDLE;
            end
          end
        end
        PH_WB:
          if (wb_ready) begin
            st_q[v_set][v_way] <= 2'd0;
            sh_q[v_set][v_way] <= '0;
            phase <= PH_IDLE;
          end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r4_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> (inv_req == '0 && !wb_valid));

  a_r5_inv_wb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((|inv_req) && wb_valid));

  a_r6_no_new_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_req) |=> ((inv_req & ~$past(inv_req)) == '0) || ($past(inv_req) == '0));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|(inv_req & inv_ack)) |=> ((inv_req & $past(inv_req & inv_ack)) == '0));

  a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag) && $stable(wb_set)));

endmodule

// File: tb/inclusive_l2_evictor_test.sv
module inclusive_l2_evictor_test;
  localparam int CORES = 2;
  localparam int NL1   = 2 * CORES;
  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int TAG_W = 12;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fill_valid = 1'b0;
  logic             fill_ready;
  logic [SET_W-1:0] fill_set = '0;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [1:0]       fill_state = 2'd0;
  logic [NL1-1:0]   fill_sharers = '0;
  logic [WAY_W-1:0] fill_way;
  logic [NL1-1:0]   inv_req;
  logic [SET_W-1:0] inv_set;
  logic [TAG_W-1:0] inv_tag;
  logic [NL1-1:0]   inv_ack = '0;
  logic [NL1-1:0]   inv_dirty = '0;
  logic             wb_valid;
  logic             wb_ready = 1'b0;
  logic [SET_W-1:0] wb_set;
  logic [TAG_W-1:0] wb_tag;

  inclusive_l2_evictor #(.CORES(CORES), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_set(fill_set), .fill_tag(fill_tag), .fill_state(fill_state),
    .fill_sharers(fill_sharers), .fill_way(fill_way), .inv_req(inv_req),
    .inv_set(inv_set), .inv_tag(inv_tag), .inv_ack(inv_ack), .inv_dirty(inv_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_set(wb_set), .wb_tag(wb_tag));

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [TAG_W-1:0] mtag [WAYS];
  int               mst  [WAYS];
  logic [NL1-1:0]   msh  [WAYS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_free(input int set, input int tag, input int st, input int sh, input int exp_way);
    @(negedge clk);
    fill_set = SET_W'(set); fill_tag = TAG_W'(tag);
    fill_state = 2'(st); fill_sharers = NL1'(sh); fill_valid = 1'b1;
    #1;
    chk(fill_ready, "R2 ready with free way", int'(fill_ready), 1);
    chk(fill_way == WAY_W'(exp_way), "R2 lowest free way", int'(fill_way), exp_way);
    @(negedge clk);
    fill_valid = 1'b0;
    if (set == 0) begin
      mtag[exp_way] = TAG_W'(tag); mst[exp_way] = st; msh[exp_way] = NL1'(sh);
    end
  endtask

  task automatic evict(input int tag, input int st, input int sh, input int dmask, input int exp_vic);
    logic [NL1-1:0] exp_sh, acked, low;
    bit exp_wb, saw_inv, saw_wb;
    int wb_cyc;
    exp_sh  = msh[exp_vic];
    exp_wb  = (mst[exp_vic] >= 2) || ((NL1'(dmask) & exp_sh) != '0);
    acked   = '0;
    saw_inv = 1'b0; saw_wb = 1'b0; wb_cyc = 0;
    @(negedge clk);
    fill_set = '0; fill_tag = TAG_W'(tag);
    fill_state = 2'(st); fill_sharers = NL1'(sh); fill_valid = 1'b1;
    #1;
    chk(!fill_ready, "R4 ready low on full set", int'(fill_ready), 0);
    forever begin
      @(negedge clk);
      inv_ack = '0; inv_dirty = '0; wb_ready = 1'b0;
      #1;
      if (fill_ready) break;
      if (inv_req != '0) begin
        if (!saw_inv) begin
          chk(inv_tag == mtag[exp_vic], "R5 inv tag", int'(inv_tag), int'(mtag[exp_vic]));
          chk(inv_set == '0, "R5 inv set", int'(inv_set), 0);
        end
        chk(inv_req == (exp_sh & ~acked), "R6 requests held until ack", int'(inv_req), int'(exp_sh & ~acked));
        saw_inv = 1'b1;
        low = inv_req & (~inv_req + 1'b1);
        acked = acked | low;
        inv_ack = low | ~exp_sh;
        inv_dirty = (low & NL1'(dmask)) | ~exp_sh;
      end
      if (wb_valid) begin
        if (!saw_wb)
          chk(wb_tag == mtag[exp_vic], "R9 wb tag", int'(wb_tag), int'(mtag[exp_vic]));
        chk(acked == exp_sh, "R8 wb after all acks", int'(acked), int'(exp_sh));
        saw_wb = 1'b1;
        wb_cyc++;
        if (wb_cyc >= 3) wb_ready = 1'b1;
      end
    end
    chk(fill_way == WAY_W'(exp_vic), "R3 plru victim", int'(fill_way), exp_vic);
    chk(saw_inv == (exp_sh != '0), "R7 invalidation phase iff sharers", int'(saw_inv), int'(exp_sh != '0));
    chk(saw_wb == exp_wb, "R8 writeback decision", int'(saw_wb), int'(exp_wb));
    if (exp_wb) chk(wb_cyc == 3, "R9 one held writeback", wb_cyc, 3);
    @(negedge clk);
    fill_valid = 1'b0;
    mtag[exp_vic] = TAG_W'(tag); mst[exp_vic] = st; msh[exp_vic] = NL1'(sh);
  endtask

  initial begin
    int seq [4] = '{0, 2, 1, 3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < SETS; s++) begin
      @(negedge clk);
      fill_set = SET_W'(s);
      #1;
      chk(fill_ready && fill_way == '0, "R1 reset free way 0", int'(fill_way), 0);
      chk(inv_req == '0 && !wb_valid, "R1 reset quiet", int'(inv_req), 0);
    end
    fill_free(0, 'h010, 3, 'h0, 0);
    fill_free(0, 'h011, 1, 'h5, 1);
    fill_free(0, 'h012, 2, 'hF, 2);
    fill_free(0, 'h013, 1, 'h0, 3);
    for (int k = 0; k < 36; k++) begin
      int st, sh, dm;
      st = 1 + (k % 3);
      sh = (k * 5) % 16;
      dm = (k % 5 == 0) ? 'hF : ((k % 5 == 2) ? 'h2 : 0);
      evict('h100 + k, st, sh, dm, seq[k % 4]);
    end
    fill_free(1, 'h200, 3, 'h3, 0);
    fill_free(1, 'h201, 1, 'h0, 1);
    @(negedge clk);
    fill_set = SET_W'(2);
    #1;
    chk(fill_ready && fill_way == '0, "R10 other set untouched", int'(fill_way), 0);
    @(negedge clk);
    fill_set = '0;
    #1;
    chk(!fill_ready, "R10 set 0 still full", int'(fill_ready), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule